// File: doc/BRIEF.md
# Raster Timing Generator with Sync Control

This block produces the scan timing of a progressive display from a set of programmable registers. A horizontal counter steps once per pixel clock and a vertical counter steps once per line. Comparators on the two counters produce a display-enable window, a horizontal and a vertical sync pulse, and a one-cycle prefetch pulse at a chosen pixel of every line. The prefetch pulse tells a pixel fetch engine to start loading the next line early.

Every geometry register holds the final count of its interval, which is the count minus one. A sync-control register sets the polarity of each sync and can force either sync, or both, to its inactive level for power saving. A display-control bit blanks the video enable while both syncs keep running. A control register starts the counters and, as a separate bit, opens the active-video window. Software clears both control bits while it rewrites the geometry.

Top module: `raster_timing_gen`

## Requirements
- R1: After synchronous reset every register reads zero. pos_x and pos_y are 0, and hsync, vsync, disp_en and prefetch are all 0.
- R2: While run (control bit 0) is set, pos_x counts up by one per clock. When pos_x is at or above the horizontal last-pixel value it returns to 0, and on that clock pos_y advances. pos_y returns to 0 when it wraps at or above the vertical last-line value.
- R3: disp_en is 1 exactly when run and refresh (control bit 1) are set, display-off is clear, pos_x is at or below the horizontal visible-last value, and pos_y is at or below the vertical visible-last value.
- R4: Before polarity is applied, hsync is asserted when pos_x is greater than the hsync-begin value and at or below the hsync-end value. vsync uses the same rule with pos_y and the vsync registers. With no inversion the asserted level is 1.
- R5: Sync-control bit 3 inverts hsync and bit 4 inverts vsync.
- R6: Sync-control bit 1 forces both syncs off, bit 5 forces hsync off and bit 6 forces vsync off. A forced-off sync sits at its inactive level, which is the value of its inversion bit.
- R7: Display-control bit 1 forces disp_en to 0 while hsync and vsync continue unchanged.
- R8: prefetch is 1 for exactly the clock in which run is set and pos_x equals the prefetch register, so it fires once per line.
- R9: While run is clear, both counters are held at 0, both syncs sit at their inactive level, and prefetch and disp_en are 0.
- R10: With run set and refresh clear, the counters and syncs keep running and disp_en stays 0.
- R11: A write takes effect on the clock edge on which wr_en is sampled high. The register indices are: 0 control, 1 h last pixel, 2 h visible last, 3 hsync begin, 4 hsync end, 5 v last line, 6 v visible last, 7 vsync begin, 8 vsync end, 9 prefetch pixel, 10 sync control, 11 display control. Writes to any other index change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | DATA_W | Register write value |
| hsync | output | 1 | Horizontal sync after polarity and forcing |
| vsync | output | 1 | Vertical sync after polarity and forcing |
| disp_en | output | 1 | Active-video enable |
| pos_x | output | CNT_W | Current pixel count in the line |
| pos_y | output | CNT_W | Current line count in the frame |
| prefetch | output | 1 | One-clock pulse at the prefetch pixel |

## Verification
The bench builds the block with CNT_W = 8 and the default DATA_W = 16. It programs a tiny 10-pixel by 6-line raster. With this geometry each frame lasts 60 clocks, so line wraps, frame wraps and both sync windows come round many times. The corner cases can then be compared on every cycle: a one-line vsync, the prefetch pixel lying inside the sync pulse, and each forcing and inversion combination.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

    localparam int REG_IDX_W = 4;
    localparam int WIN_W     = 32;
    localparam int N_TIM     = 9;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_CTRL     = 4'd0,
        RG_H_LAST   = 4'd1,
        RG_H_VIS    = 4'd2,
        RG_HS_BEG   = 4'd3,
        RG_HS_END   = 4'd4,
        RG_V_LAST   = 4'd5,
        RG_V_VIS    = 4'd6,
        RG_VS_BEG   = 4'd7,
        RG_VS_END   = 4'd8,
        RG_PREFETCH = 4'd9,
        RG_SYNC     = 4'd10,
        RG_DISP     = 4'd11
    } reg_idx_e;

    // positions inside the geometry array (index = register index - 1)
    localparam int TI_H_LAST   = 0;
    localparam int TI_H_VIS    = 1;
    localparam int TI_HS_BEG   = 2;
    localparam int TI_HS_END   = 3;
    localparam int TI_V_LAST   = 4;
    localparam int TI_V_VIS    = 5;
    localparam int TI_VS_BEG   = 6;
    localparam int TI_VS_END   = 7;
    localparam int TI_PREFETCH = 8;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_REFRESH_BIT = 1;
    localparam int SC_OFF_ALL_BIT   = 1;
    localparam int SC_INV_H_BIT     = 3;
    localparam int SC_INV_V_BIT     = 4;
    localparam int SC_OFF_H_BIT     = 5;
    localparam int SC_OFF_V_BIT     = 6;
    localparam int DISP_BLANK_BIT   = 1;

    typedef struct packed {
        logic refresh;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic off_v;
        logic off_h;
        logic inv_v;
        logic inv_h;
        logic off_all;
    } sync_ctl_t;

    // count lies after 'beg' and up to and including 'fin'
    function automatic logic in_window(logic [WIN_W-1:0] c,
                                       logic [WIN_W-1:0] beg,
                                       logic [WIN_W-1:0] fin);
        return (c > beg) && (c <= fin);
    endfunction

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_timing_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     tim [N_TIM],
    output ctrl_t                 ctrl,
    output sync_ctl_t             sctl,
    output logic                  disp_off
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TIM; i++) tim[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_TIM; i++) begin
                if (wr_addr == REG_IDX_W'(int'(RG_H_LAST) + i))
                    tim[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            sctl     <= '0;
            disp_off <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                RG_CTRL: begin
                    ctrl.run     <= wr_data[CTRL_RUN_BIT];
                    ctrl.refresh <= wr_data[CTRL_REFRESH_BIT];
                end
                RG_SYNC: begin
                    sctl.off_all <= wr_data[SC_OFF_ALL_BIT];
                    sctl.inv_h   <= wr_data[SC_INV_H_BIT];
                    sctl.inv_v   <= wr_data[SC_INV_V_BIT];
                    sctl.off_h   <= wr_data[SC_OFF_H_BIT];
                    sctl.off_v   <= wr_data[SC_OFF_V_BIT];
                end
                RG_DISP: disp_off <= wr_data[DISP_BLANK_BIT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/raster_axis_cnt.sv
module raster_axis_cnt #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              adv,
    input  logic [DATA_W-1:0] last,
    output logic [CNT_W-1:0]  cnt,
    output logic              wrap
);

    // restart at or beyond the programmed last count, so a shrunk
    // geometry never lets the counter run off to its full range
    assign wrap = adv && (DATA_W'(cnt) >= last);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (adv)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/raster_sync_shape.sv
module raster_sync_shape
    import raster_timing_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic              run,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] beg,
    input  logic [DATA_W-1:0] fin,
    input  logic              inv,
    input  logic              force_off,
    output logic              sync_out
);

    logic raw;

    assign raw      = in_window(WIN_W'(cnt), WIN_W'(beg), WIN_W'(fin));
    // inactive level equals the inversion bit
    assign sync_out = (!run || force_off) ? inv : (raw ^ inv);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_timing_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 disp_en,
    output logic [CNT_W-1:0]     pos_x,
    output logic [CNT_W-1:0]     pos_y,
    output logic                 prefetch
);

    logic [DATA_W-1:0] tim [N_TIM];
    ctrl_t             ctrl_q;
    sync_ctl_t         sctl_q;
    logic              disp_off_q;

    logic run_q, refresh_q, inv_h, inv_v, off_all;
    logic [DATA_W-1:0] h_last, h_vis, v_vis, pf_pt;
    logic h_wrap, v_wrap_unused;

    raster_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tim      (tim),
        .ctrl     (ctrl_q),
        .sctl     (sctl_q),
        .disp_off (disp_off_q)
    );

    assign run_q     = ctrl_q.run;
    assign refresh_q = ctrl_q.refresh;
    assign inv_h     = sctl_q.inv_h;
    assign inv_v     = sctl_q.inv_v;
    assign off_all   = sctl_q.off_all;
    assign h_last    = tim[TI_H_LAST];
    assign h_vis     = tim[TI_H_VIS];
    assign v_vis     = tim[TI_V_VIS];
    assign pf_pt     = tim[TI_PREFETCH];

    raster_axis_cnt #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_hcnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .adv  (1'b1),
        .last (h_last),
        .cnt  (pos_x),
        .wrap (h_wrap)
    );

    raster_axis_cnt #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_vcnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .adv  (h_wrap),
        .last (tim[TI_V_LAST]),
        .cnt  (pos_y),
        .wrap (v_wrap_unused)
    );

    raster_sync_shape #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_hs (
        .run       (run_q),
        .cnt       (pos_x),
        .beg       (tim[TI_HS_BEG]),
        .fin       (tim[TI_HS_END]),
        .inv       (inv_h),
        .force_off (off_all || sctl_q.off_h),
        .sync_out  (hsync)
    );

    raster_sync_shape #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_vs (
        .run       (run_q),
        .cnt       (pos_y),
        .beg       (tim[TI_VS_BEG]),
        .fin       (tim[TI_VS_END]),
        .inv       (inv_v),
        .force_off (off_all || sctl_q.off_v),
        .sync_out  (vsync)
    );

    assign disp_en  = run_q && refresh_q && !disp_off_q
                   && (DATA_W'(pos_x) <= h_vis)
                   && (DATA_W'(pos_y) <= v_vis);
    assign prefetch = run_q && (DATA_W'(pos_x) == pf_pt);

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              disp_off,
    input logic              off_all,
    input logic              inv_h,
    input logic              inv_v,
    input logic [DATA_W-1:0] h_last,
    input logic [DATA_W-1:0] h_vis,
    input logic [DATA_W-1:0] v_vis,
    input logic [DATA_W-1:0] pf_pt,
    input logic [CNT_W-1:0]  pos_x,
    input logic [CNT_W-1:0]  pos_y,
    input logic              hsync,
    input logic              vsync,
    input logic              disp_en,
    input logic              prefetch
);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pos_x == '0 && pos_y == '0));

    p_hstep_r2: assert property (@(posedge clk) disable iff (rst)
        (run && DATA_W'(pos_x) < h_last) |=> (pos_x == CNT_W'($past(pos_x) + 1'b1)));

    p_de_window_r3: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> (run && DATA_W'(pos_x) <= h_vis && DATA_W'(pos_y) <= v_vis));

    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        disp_off |-> !disp_en);

    p_force_off_r6: assert property (@(posedge clk) disable iff (rst)
        off_all |-> (hsync == inv_h && vsync == inv_v));

    p_prefetch_r8: assert property (@(posedge clk) disable iff (rst)
        prefetch |-> (run && DATA_W'(pos_x) == pf_pt));

endmodule

bind raster_timing_gen raster_timing_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .disp_off (disp_off_q),
    .off_all  (off_all),
    .inv_h    (inv_h),
    .inv_v    (inv_v),
    .h_last   (h_last),
    .h_vis    (h_vis),
    .v_vis    (v_vis),
    .pf_pt    (pf_pt),
    .pos_x    (pos_x),
    .pos_y    (pos_y),
    .hsync    (hsync),
    .vsync    (vsync),
    .disp_en  (disp_en),
    .prefetch (prefetch)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              hsync, vsync, disp_en, prefetch;
    logic [CNT_W-1:0]  pos_x, pos_y;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of the programmed state
    int m_tim [9];
    logic [1:0] m_ctrl = '0;
    logic [6:0] m_sync = '0;
    logic       m_doff = 1'b0;
    int ex = 0;
    int ey = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_raster_timing_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .pos_x(pos_x), .pos_y(pos_y), .prefetch(prefetch)
    );

    // reference raster position
    always @(posedge clk) begin
        if (rst || !m_ctrl[0]) begin
            ex <= 0;
            ey <= 0;
        end else if (ex >= m_tim[0]) begin
            ex <= 0;
            ey <= (ey >= m_tim[4]) ? 0 : ey + 1;
        end else begin
            ex <= ex + 1;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(int idx, int val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(idx);
        wr_data = DATA_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (idx == 0) m_ctrl = 2'(val);
        else if (idx >= 1 && idx <= 9) m_tim[idx-1] = val;
        else if (idx == 10) m_sync = 7'(val);
        else if (idx == 11) m_doff = val[1];
    endtask

    task automatic compare(string t_pos, string t_de, string t_sync, string t_pf);
        bit run, hraw, vraw, hoff, voff, e_de, e_hs, e_vs, e_pf;
        run  = m_ctrl[0];
        hraw = (ex > m_tim[2]) && (ex <= m_tim[3]);
        vraw = (ey > m_tim[6]) && (ey <= m_tim[7]);
        hoff = !run || m_sync[1] || m_sync[5];
        voff = !run || m_sync[1] || m_sync[6];
        e_hs = hoff ? m_sync[3] : (hraw ^ m_sync[3]);
        e_vs = voff ? m_sync[4] : (vraw ^ m_sync[4]);
        e_de = run && m_ctrl[1] && !m_doff && ex <= m_tim[1] && ey <= m_tim[5];
        e_pf = run && (ex == m_tim[8]);
        chk(t_pos,  "pos_x",    int'(pos_x),    ex);
        chk(t_pos,  "pos_y",    int'(pos_y),    ey);
        chk(t_de,   "disp_en",  int'(disp_en),  int'(e_de));
        chk(t_sync, "hsync",    int'(hsync),    int'(e_hs));
        chk(t_sync, "vsync",    int'(vsync),    int'(e_vs));
        chk(t_pf,   "prefetch", int'(prefetch), int'(e_pf));
    endtask

    task automatic run_cycles(int n, string t_pos, string t_de, string t_sync, string t_pf);
        for (int i = 0; i < n; i++) begin
            compare(t_pos, t_de, t_sync, t_pf);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1", "pos_x", int'(pos_x), 0);
        chk("R1", "pos_y", int'(pos_y), 0);
        chk("R1", "hsync", int'(hsync), 0);
        chk("R1", "vsync", int'(vsync), 0);
        chk("R1", "disp_en", int'(disp_en), 0);
        chk("R1", "prefetch", int'(prefetch), 0);
    endtask

    task automatic t_frames();
        write_reg(1, 9);  write_reg(2, 5);  write_reg(3, 6);
        write_reg(4, 7);  write_reg(5, 5);  write_reg(6, 3);
        write_reg(7, 3);  write_reg(8, 4);  write_reg(9, 7);
        run_cycles(3, "R9", "R9", "R9", "R9");
        write_reg(0, 3);
        chk("R11", "pos_x after run write", int'(pos_x), 0);
        run_cycles(130, "R2", "R3", "R4", "R8");
    endtask

    task automatic t_invert();
        write_reg(10, 'h18);
        compare("R11", "R11", "R11", "R11");
        run_cycles(60, "R2", "R3", "R5", "R8");
    endtask

    task automatic t_force();
        write_reg(10, 'h02); run_cycles(60, "R2", "R3", "R6", "R8");
        write_reg(10, 'h20); run_cycles(60, "R2", "R3", "R6", "R8");
        write_reg(10, 'h40); run_cycles(60, "R2", "R3", "R6", "R8");
        write_reg(10, 'h38); run_cycles(60, "R2", "R3", "R6", "R8");
        write_reg(10, 'h1A); run_cycles(30, "R2", "R3", "R6", "R8");
        write_reg(10, 0);
    endtask

    task automatic t_display_off();
        write_reg(11, 'h02); run_cycles(60, "R2", "R7", "R7", "R8");
        write_reg(11, 0);    run_cycles(20, "R2", "R7", "R4", "R8");
    endtask

    task automatic t_refresh_off();
        write_reg(0, 1); run_cycles(60, "R10", "R10", "R10", "R10");
        write_reg(0, 3); run_cycles(10, "R2", "R3", "R4", "R8");
    endtask

    task automatic t_ignored_index();
        write_reg(13, 0);
        write_reg(15, 'hFFFF);
        run_cycles(60, "R11", "R11", "R11", "R11");
    endtask

    task automatic t_disable();
        write_reg(10, 'h18);
        write_reg(0, 0);
        run_cycles(20, "R9", "R9", "R9", "R9");
        write_reg(10, 0);
        write_reg(0, 3);
        run_cycles(25, "R2", "R3", "R4", "R8");
    endtask

    initial begin
        for (int i = 0; i < 9; i++) m_tim[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frames();
        t_invert();
        t_force();
        t_display_off();
        t_refresh_off();
        t_ignored_index();
        t_disable();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule